// File: doc/BRIEF.md
# Memory Type Range Resolver

This block works out the caching memory type for one physical access. Two sources feed it. A bank of variable address ranges, each described by a base and a mask register, gives a range type, with a default type for addresses that no range covers. A page-level attribute table is indexed by three attribute bits taken from the page entry, and it gives a page type. A fixed precedence rule merges the two into the effective type.

A simple addressed port writes all configuration: one default-type register, one attribute table register (eight one-byte entries) and a base/mask pair for each range. A lookup request carries the physical address and the three page bits. The merged type appears on the output one clock later. The first mebibyte can be held at the default type by an enable bit. No per-range table is kept for that region.

Top module: `mtr_resolver`

## Requirements
- R1: Type codes on `rsp_type` are UC=0, WC=1, WT=4, WP=5, WB=6 and UC-=7. `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high, and it carries that request's result. After reset `rsp_valid` is 0 and `rsp_type` is 0.
- R2: A write with `cfg_we` high stores `cfg_wdata` into the register chosen by `cfg_idx`: index 0 is the default-type register, index 1 is the attribute table, index 2+2k is the base of range k and index 3+2k is the mask of range k. Writes to indices 18 to 31 change nothing.
- R3: The page index is {`req_sel`, `req_cd`, `req_wt`} (sel is the most significant bit). Entry i of the attribute table is byte i of that register, and its type is bits [8i+2:8i].
- R4: After reset the attribute table holds, from entry 0 to entry 7: WB, WT, UC-, UC, WB, WT, UC-, UC.
- R5: Bit 11 of the default-type register is the global enable, and it resets to 0. While it is 0 the range type is UC, so every response is UC.
- R6: Range k matches when address bits [35:12] and base bits [35:12] agree in every position where mask bits [35:12] are 1, and mask bit 11 (valid) is 1. The range's type is base bits [2:0]. A range whose valid bit is 0 never matches.
- R7: With the global enable set and no range matching, the range type is the default type in bits [2:0] of the default-type register.
- R8: Among several matching ranges: if any is UC, the range type is UC. Otherwise, if all of them are WT or WB and at least one is WT, the range type is WT. Otherwise the type of the lowest-numbered matching range is used.
- R9: When bit 10 of the default-type register is set and the address is below 0x100000, the range type is the default type and the variable ranges are ignored.
- R10: The effective type is UC if either source is UC. Otherwise it is WC if the page type is WC. Otherwise it is WT if either source is WT. Otherwise it is the page type.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | 5 | Register index for the write |
| cfg_wdata | input | 64 | Write data |
| req_valid | input | 1 | Lookup request |
| req_addr | input | 36 | Physical address of the lookup |
| req_wt | input | 1 | Page write-through bit (index bit 0) |
| req_cd | input | 1 | Page cache-disable bit (index bit 1) |
| req_sel | input | 1 | Page attribute select bit (index bit 2) |
| rsp_valid | output | 1 | Result valid, one cycle after the request |
| rsp_type | output | 3 | Effective memory type code |

## Verification
The bench targets overlapping ranges. A UC range nested inside a WT range must still give UC. A WT range overlapping a WB range must give WT. Where WT overlaps WP, the lowest-numbered range must win; a priority encoder scanning from the wrong end would report WP, and that shows up as WB after merging. The bench walks every page-index bit on its own after reloading the table, so swapped index bits produce the wrong entry. It also checks an invalid range carrying a live base, the first-mebibyte override and a write to an unused index. Any of these aliased onto real state would change a later response.

// File: rtl/mtr_pkg.sv
package mtr_pkg;

    typedef logic [2:0] mtype_t;

    localparam mtype_t MT_UC  = 3'd0;
    localparam mtype_t MT_WC  = 3'd1;
    localparam mtype_t MT_WT  = 3'd4;
    localparam mtype_t MT_WP  = 3'd5;
    localparam mtype_t MT_WB  = 3'd6;
    localparam mtype_t MT_UCM = 3'd7;

    // attribute table contents after reset: WB WT UC- UC WB WT UC- UC
    localparam logic [63:0] PAGE_TBL_RST = 64'h0007_0406_0007_0406;

    typedef struct packed {
        logic   en;      // global enable
        logic   low_en;  // first-MiB override enable
        mtype_t dflt;
    } dflt_cfg_t;

    // precedence merge of range-derived and page-derived types
    function automatic mtype_t merge_types(input mtype_t rng, input mtype_t pg);
        if (rng == MT_UC || pg == MT_UC)      return MT_UC;
        else if (pg == MT_WC)                 return MT_WC;
        else if (rng == MT_WT || pg == MT_WT) return MT_WT;
        else                                  return pg;
    endfunction

endpackage

// File: rtl/mtr_regfile.sv
module mtr_regfile
    import mtr_pkg::*;
#(
    parameter int PA_W   = 36,
    parameter int NRANGE = 8,
    parameter int IDX_W  = 5,
    localparam int AH_W  = PA_W - 12
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        cfg_we,
    input  logic [IDX_W-1:0]            cfg_idx,
    input  logic [63:0]                 cfg_wdata,
    output dflt_cfg_t                   dflt_q,
    output logic [63:0]                 page_tbl_q,
    output logic [NRANGE-1:0][AH_W-1:0] base_addr_q,
    output logic [NRANGE-1:0][2:0]      base_type_q,
    output logic [NRANGE-1:0][AH_W-1:0] mask_addr_q,
    output logic [NRANGE-1:0]           mask_vld_q
);

    localparam logic [IDX_W-1:0] IDX_DFLT = IDX_W'(0);
    localparam logic [IDX_W-1:0] IDX_PAGE = IDX_W'(1);

    logic unused_wdata;
    assign unused_wdata = ^{cfg_wdata[63:PA_W], cfg_wdata[9:3]};

    always_ff @(posedge clk) begin
        if (rst) begin
            dflt_q     <= '{en: 1'b0, low_en: 1'b0, dflt: MT_UC};
            page_tbl_q <= PAGE_TBL_RST;
        end else if (cfg_we) begin
            if (cfg_idx == IDX_DFLT)
                dflt_q <= '{en: cfg_wdata[11], low_en: cfg_wdata[10], dflt: cfg_wdata[2:0]};
            if (cfg_idx == IDX_PAGE)
                page_tbl_q <= cfg_wdata;
        end
    end

    for (genvar g = 0; g < NRANGE; g++) begin : g_rng
        localparam logic [IDX_W-1:0] IDX_BASE = IDX_W'(2 + 2 * g);
        localparam logic [IDX_W-1:0] IDX_MASK = IDX_W'(3 + 2 * g);

        always_ff @(posedge clk) begin
            if (rst) begin
                base_addr_q[g] <= '0;
                base_type_q[g] <= MT_UC;
                mask_addr_q[g] <= '0;
                mask_vld_q[g]  <= 1'b0;
            end else if (cfg_we) begin
                if (cfg_idx == IDX_BASE) begin
                    base_addr_q[g] <= cfg_wdata[PA_W-1:12];
                    base_type_q[g] <= cfg_wdata[2:0];
                end
                if (cfg_idx == IDX_MASK) begin
                    mask_addr_q[g] <= cfg_wdata[PA_W-1:12];
                    mask_vld_q[g]  <= cfg_wdata[11];
                end
            end
        end
    end

    // R2: without a write strobe the attribute table holds
    p_hold_table_r2: assert property (@(posedge clk) disable iff (rst)
        !cfg_we |=> $stable(page_tbl_q));

endmodule

// File: rtl/mtr_range_unit.sv
module mtr_range_unit
    import mtr_pkg::*;
#(
    parameter int PA_W   = 36,
    parameter int NRANGE = 8,
    localparam int AH_W  = PA_W - 12
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [PA_W-1:0]             addr,
    input  dflt_cfg_t                   dflt_q,
    input  logic [NRANGE-1:0][AH_W-1:0] base_addr_q,
    input  logic [NRANGE-1:0][2:0]      base_type_q,
    input  logic [NRANGE-1:0][AH_W-1:0] mask_addr_q,
    input  logic [NRANGE-1:0]           mask_vld_q,
    output mtype_t                      rng_type
);

    logic [NRANGE-1:0] hit, hit_uc, hit_wt, hit_other;
    logic              low_region;
    mtype_t            first_type;

    logic unused_addr;
    assign unused_addr = ^addr[11:0];

    assign low_region = (addr[PA_W-1:20] == '0);

    for (genvar g = 0; g < NRANGE; g++) begin : g_cmp
        assign hit[g]       = mask_vld_q[g] &&
                              (((addr[PA_W-1:12] ^ base_addr_q[g]) & mask_addr_q[g]) == '0);
        assign hit_uc[g]    = hit[g] && (base_type_q[g] == MT_UC);
        assign hit_wt[g]    = hit[g] && (base_type_q[g] == MT_WT);
        assign hit_other[g] = hit[g] && (base_type_q[g] != MT_WT) && (base_type_q[g] != MT_WB);
    end

    always_comb begin
        first_type = MT_UC;
        for (int i = NRANGE - 1; i >= 0; i--)
            if (hit[i]) first_type = base_type_q[i];
    end

    always_comb begin
        if (!dflt_q.en)                         rng_type = MT_UC;
        else if (dflt_q.low_en && low_region)   rng_type = dflt_q.dflt;
        else if (hit == '0)                     rng_type = dflt_q.dflt;
        else if (|hit_uc)                       rng_type = MT_UC;
        else if (|hit_wt && !(|hit_other))      rng_type = MT_WT;
        else                                    rng_type = first_type;
    end

    p_disabled_uc_r5: assert property (@(posedge clk) disable iff (rst)
        !dflt_q.en |-> rng_type == MT_UC);

    p_uc_wins_r8: assert property (@(posedge clk) disable iff (rst)
        (dflt_q.en && !(dflt_q.low_en && low_region) && |hit_uc) |-> rng_type == MT_UC);

    p_nomatch_default_r7: assert property (@(posedge clk) disable iff (rst)
        (dflt_q.en && hit == '0) |-> rng_type == dflt_q.dflt);

    p_low_override_r9: assert property (@(posedge clk) disable iff (rst)
        (dflt_q.en && dflt_q.low_en && low_region) |-> rng_type == dflt_q.dflt);

endmodule

// File: rtl/mtr_resolver.sv
module mtr_resolver
    import mtr_pkg::*;
#(
    parameter int PA_W   = 36,
    parameter int NRANGE = 8,
    localparam int IDX_W = $clog2(2 + 2 * NRANGE + 1),
    localparam int AH_W  = PA_W - 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic [63:0]      cfg_wdata,
    input  logic             req_valid,
    input  logic [PA_W-1:0]  req_addr,
    input  logic             req_wt,
    input  logic             req_cd,
    input  logic             req_sel,
    output logic             rsp_valid,
    output logic [2:0]       rsp_type
);

    dflt_cfg_t                   dflt_q;
    logic [63:0]                 page_tbl_q;
    logic [NRANGE-1:0][AH_W-1:0] base_addr_q, mask_addr_q;
    logic [NRANGE-1:0][2:0]      base_type_q;
    logic [NRANGE-1:0]           mask_vld_q;
    mtype_t                      rng_type, page_type;
    logic [2:0]                  page_idx;

    mtr_regfile #(.PA_W(PA_W), .NRANGE(NRANGE), .IDX_W(IDX_W)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .cfg_we      (cfg_we),
        .cfg_idx     (cfg_idx),
        .cfg_wdata   (cfg_wdata),
        .dflt_q      (dflt_q),
        .page_tbl_q  (page_tbl_q),
        .base_addr_q (base_addr_q),
        .base_type_q (base_type_q),
        .mask_addr_q (mask_addr_q),
        .mask_vld_q  (mask_vld_q)
    );

    mtr_range_unit #(.PA_W(PA_W), .NRANGE(NRANGE)) u_rng (
        .clk         (clk),
        .rst         (rst),
        .addr        (req_addr),
        .dflt_q      (dflt_q),
        .base_addr_q (base_addr_q),
        .base_type_q (base_type_q),
        .mask_addr_q (mask_addr_q),
        .mask_vld_q  (mask_vld_q),
        .rng_type    (rng_type)
    );

    assign page_idx  = {req_sel, req_cd, req_wt};
    assign page_type = page_tbl_q[8 * page_idx +: 3];

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_type  <= MT_UC;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) rsp_type <= merge_types(rng_type, page_type);
        end
    end

    p_rsp_follow_r1: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    p_rsp_idle_r1: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    p_page_uc_r10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && page_type == MT_UC) |=> rsp_type == MT_UC);

    p_range_uc_r10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && rng_type == MT_UC) |=> rsp_type == MT_UC);

endmodule

// File: tb/mtr_resolver_test.sv
module mtr_resolver_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_idx = '0;
    logic [63:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic [35:0] req_addr = '0;
    logic        req_wt = 1'b0, req_cd = 1'b0, req_sel = 1'b0;
    logic        rsp_valid;
    logic [2:0]  rsp_type;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [2:0] exp_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    mtr_resolver uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_addr(req_addr), .req_wt(req_wt), .req_cd(req_cd),
        .req_sel(req_sel), .rsp_valid(rsp_valid), .rsp_type(rsp_type)
    );

    task automatic wr(input logic [4:0] idx, input logic [63:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // driver: issues one lookup and queues its expected type
    task automatic look(input logic [35:0] a, input logic [2:0] pidx,
                        input logic [2:0] expv, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        {req_sel, req_cd, req_wt} = pidx;
        exp_q.push_back(expv);
        tag_q.push_back(tag);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // monitor: compares every response with the queue head
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R1 unexpected response: actual %0d expected none", rsp_type);
            end else begin
                automatic logic [2:0] e = exp_q.pop_front();
                automatic string      t = tag_q.pop_front();
                if (rsp_type !== e) begin
                    errors++;
                    $display("FAIL %s: actual %0d expected %0d", t, rsp_type, e);
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(rsp_valid == 1'b0 && rsp_type == 3'd0, "R1 reset outputs", {rsp_valid, rsp_type}, 0);

        // R5: global enable clear after reset, WB page entry still gives UC
        look(36'h0_4000_0000, 3'd0, 3'd0, "R5 disabled at reset");

        // enable, default WB; R4 reset table walk
        wr(5'd0, 64'h806);
        look(36'h0_4000_0000, 3'd0, 3'd6, "R4 entry0 WB");
        look(36'h0_4000_0000, 3'd1, 3'd4, "R4 entry1 WT");
        look(36'h0_4000_0000, 3'd2, 3'd7, "R4 entry2 UC-");
        look(36'h0_4000_0000, 3'd3, 3'd0, "R4 entry3 UC");
        look(36'h0_4000_0000, 3'd4, 3'd6, "R4 entry4 WB");
        look(36'h0_4000_0000, 3'd7, 3'd0, "R4 entry7 UC");

        // R3: reload table: e0 WC, e1 WT, e2 WB, e3 UC-, e4 UC, e5 WC, e6 WT, e7 WP
        wr(5'd1, 64'h0504_0100_0706_0401);
        look(36'h0_4000_0000, 3'd0, 3'd1, "R3 entry0 WC");
        look(36'h0_4000_0000, 3'd1, 3'd4, "R3 wt bit selects entry1");
        look(36'h0_4000_0000, 3'd2, 3'd6, "R3 cd bit selects entry2");
        look(36'h0_4000_0000, 3'd4, 3'd0, "R3 sel bit selects entry4");
        look(36'h0_4000_0000, 3'd7, 3'd5, "R3 entry7 WP");

        // R6: range0 UC 1 MiB at 0x1_0000_0000
        wr(5'd2, 64'h1_0000_0000);
        wr(5'd3, 64'hF_FFF0_0800);
        look(36'h1_0000_5000, 3'd2, 3'd0, "R6 inside range0");
        look(36'h1_0010_0000, 3'd2, 3'd6, "R7 just past range0 default");
        // R6: range1 WT base but valid clear
        wr(5'd4, 64'h2_0000_0004);
        wr(5'd5, 64'hF_FFF0_0000);
        look(36'h2_0000_0000, 3'd2, 3'd6, "R6 invalid range ignored");

        // R8: range2 WT 1 MiB, range3 WB 16 MiB, range4 UC 4 KiB at 0x3_0000_0000
        wr(5'd6, 64'h3_0000_0004);
        wr(5'd7, 64'hF_FFF0_0800);
        wr(5'd8, 64'h3_0000_0006);
        wr(5'd9, 64'hF_FF00_0800);
        look(36'h3_0000_1000, 3'd2, 3'd4, "R8 WT over WB");
        look(36'h3_0080_0000, 3'd2, 3'd6, "R8 WB only");
        wr(5'd10, 64'h3_0000_0000);
        wr(5'd11, 64'hF_FFFF_F800);
        look(36'h3_0000_0000, 3'd2, 3'd0, "R8 UC wins three-way overlap");
        look(36'h3_0000_1000, 3'd2, 3'd4, "R8 UC range not hit");
        // R8: range5 WT and range6 WP overlapping -> lowest index
        wr(5'd12, 64'h5_0000_0004);
        wr(5'd13, 64'hF_FFF0_0800);
        wr(5'd14, 64'h5_0000_0005);
        wr(5'd15, 64'hF_FFF0_0800);
        look(36'h5_0000_0000, 3'd2, 3'd4, "R8 lowest index wins");

        // R2: write to unused index must not disturb anything
        wr(5'd20, 64'hFFFF_FFFF_FFFF_FFFF);
        look(36'h5_0000_0000, 3'd2, 3'd4, "R2 unused index write ignored (range)");
        look(36'h0_4000_0000, 3'd0, 3'd1, "R2 unused index write ignored (table)");

        // R9: range7 UC covering the first MiB
        wr(5'd16, 64'h0);
        wr(5'd17, 64'hF_FFF0_0800);
        look(36'h0_0008_0000, 3'd2, 3'd0, "R9 override off, range applies");
        wr(5'd0, 64'hC06);
        look(36'h0_0008_0000, 3'd2, 3'd6, "R9 override on, default used");

        // R10: merge rules
        look(36'h1_0000_0000, 3'd0, 3'd0, "R10 range UC beats page WC");
        look(36'h3_0000_1000, 3'd0, 3'd1, "R10 page WC beats range WT");
        look(36'h0_4000_0000, 3'd1, 3'd4, "R10 page WT with range WB");
        look(36'h0_4000_0000, 3'd4, 3'd0, "R10 page UC with range WB");
        look(36'h3_0000_1000, 3'd7, 3'd4, "R10 range WT over page WP");
        look(36'h0_4000_0000, 3'd7, 3'd5, "R10 page WP with range WB");

        // R5: clear global enable again
        wr(5'd0, 64'h006);
        look(36'h0_4000_0000, 3'd2, 3'd0, "R5 disabled forces UC");

        repeat (3) @(negedge clk);
        chk(rsp_valid == 1'b0, "R1 idle rsp_valid", rsp_valid, 0);
        chk(exp_q.size() == 0, "R1 all responses seen", exp_q.size(), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule